// File: doc/BRIEF.md
# EEPROM Page Write Buffer and Commit Timer

This block sits between a two-wire serial protocol engine and a behavioural non-volatile array of 128 pages by 16 bytes (2048 bytes). The protocol engine hands over each received data byte as a one-cycle strobe with its word address. The block gathers these bytes into a one-page staging buffer, and each buffer slot carries a flag that marks it as loaded. The first byte of a transfer fixes the page and the starting column. Each later byte goes to the next column. The column wraps inside the page, so a transfer of more than 16 bytes overwrites the slots it loaded first.

When the protocol engine reports a STOP and at least one byte is loaded, the block starts a self-timed programming window. For a fixed number of clock cycles it holds `busy`. During that window it copies only the flagged slots into the array, and all other bytes of the page keep their contents. The flags clear when the window ends. While `busy` is high the block ignores incoming bytes, and the protocol side polls `busy` to decide whether to acknowledge. With write protection active, no byte is taken and no window starts. A START that arrives without a commit throws away whatever is staged. A registered read port gives the protocol engine access to the array.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy` and `byte_ack` are both 0.
- R2: A byte accepted while no slot is flagged takes its page from `byte_addr[10:4]` and its column from `byte_addr[3:0]`. Each later accepted byte ignores `byte_addr`, keeps that page and goes to the previous column plus one, modulo 16.
- R3: If more than 16 bytes are accepted before a commit, the column wraps and the later bytes replace the earlier bytes in the same slots.
- R4: A `stop_req` pulse with at least one flagged slot, `wp` low and `busy` low sets `busy` on the next cycle. `busy` then stays high for exactly `WR_CYCLES` cycles.
- R5: A commit writes only the flagged slots to address `{page, column}`. All other bytes of the array keep their old values. The flags clear at the end of the window.
- R6: While `wp` is 1, strobes are not acknowledged and store nothing. A `stop_req` with `wp` at 1 starts no window, discards any staged bytes and leaves the array unchanged.
- R7: A `start_seen` pulse while `busy` is low clears all flags, so a later `stop_req` starts no window and writes nothing.
- R8: A strobe that arrives while `busy` is high is not acknowledged and has no effect on the buffer or the array.
- R9: A `stop_req` with no flagged slot starts no window.
- R10: `rd_data` shows the array byte at `rd_addr` one clock after `rd_addr` is applied.
- R11: `byte_ack` is 1 on the cycle after a strobe that is accepted (`wp` low, `busy` low, no `stop_req` in the same cycle) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_stb | input | 1 | One-cycle strobe for a received data byte |
| byte_addr | input | 11 | Word address that goes with the strobe |
| byte_data | input | 8 | Received data byte |
| stop_req | input | 1 | STOP seen: request a commit |
| start_seen | input | 1 | START seen on the bus |
| wp | input | 1 | Write protection active |
| rd_addr | input | 11 | Array read address |
| rd_data | output | 8 | Registered array read data |
| byte_ack | output | 1 | Registered acceptance of the previous strobe |
| busy | output | 1 | Programming window in progress |

## Verification
On every cycle, the in-design assertions check how strobes, protection, STOP and START relate to `byte_ack`, `busy` and the flag set. These cover the start of a window, the bound on the window counter, refusal while busy or protected, and flag clearing on discard and at the end of a window. Some behaviour can only be seen through the bench's page writes and full-page read-back. This includes the column wrap and its overwrite, the exact window length, and the fact that unflagged bytes are left alone. It also covers the effect of a START abort or a late rise of write protection, which the bench sees as no write in the array.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pgc_page_buf.sv
module pgc_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int PG_W       = 7,
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  accept,
  input  logic [PG_W+COL_W-1:0] addr,
  input  logic [DATA_W-1:0]     data,
  input  logic                  discard,
  input  logic                  done,
  input  logic [COL_W-1:0]      rsel,
  output logic [PAGE_BYTES-1:0] vld,
  output logic [PG_W-1:0]       page,
  output logic [DATA_W-1:0]     rbyte
);
  logic [DATA_W-1:0]     dat_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PG_W-1:0]       page_q;
  logic [COL_W-1:0]      ptr_q;
  logic                  open;
  logic [COL_W-1:0]      col;

  assign open = |vld_q;
  assign col  = open ? ptr_q : addr[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      page_q <= '0;
      ptr_q  <= '0;
    end else if (done || discard) begin
      vld_q <= '0;
    end else if (accept) begin
      if (!open) page_q <= addr[PG_W+COL_W-1:COL_W];
      vld_q[col] <= 1'b1;
      ptr_q      <= col + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !done && !discard) dat_q[col] <= data;
  end

  assign vld   = vld_q;
  assign page  = page_q;
  assign rbyte = dat_q[rsel];

  AST_DISCARD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    discard |=> (vld == '0));                                         // R7
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (open && accept) |=> $stable(page));                              // R2
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (accept && !done && !discard) |=>
      ($countones(vld) <= $countones($past(vld)) + 1));               // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    done |=> (vld == '0));                                            // R5
endmodule

// File: rtl/pgc_timer.sv
module pgc_timer #(
  parameter int WR_CYCLES  = 500000,
  parameter int PAGE_BYTES = 16,
  localparam int CNT_W     = $clog2(WR_CYCLES + 1),
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  output logic             busy,
  output logic [COL_W-1:0] slot,
  output logic             slot_live,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] NSLT = CNT_W'(PAGE_BYTES);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy      = busy_q;
  assign done      = busy_q && (cnt_q == LAST);
  assign slot_live = busy_q && (cnt_q < NSLT);
  assign slot      = cnt_q[COL_W-1:0];

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= LAST));                                        // R4
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);                                                  // R4
endmodule

// File: rtl/pgc_array.sv
module pgc_array #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT = '1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rd
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int PAGES      = 128,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int WR_CYCLES  = 500000,
  parameter logic [DATA_W-1:0] INIT = '1,
  localparam int ADDR_W    = $clog2(PAGES * PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_stb,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_req,
  input  logic              start_seen,
  input  logic              wp,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              byte_ack,
  output logic              busy
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - COL_W;

  logic                  accept, go, discard, done, slot_live, ack_q;
  logic [COL_W-1:0]      slot;
  logic [PAGE_BYTES-1:0] vld;
  logic [PG_W-1:0]       page;
  logic [DATA_W-1:0]     sbyte;

  assign accept  = byte_stb && !busy && !wp && !stop_req;
  assign go      = stop_req && !busy && !wp && (|vld);
  assign discard = !busy && (start_seen || (stop_req && wp));

  pgc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .PG_W(PG_W)) u_buf (
    .clk(clk), .rst(rst), .accept(accept), .addr(byte_addr), .data(byte_data),
    .discard(discard), .done(done), .rsel(slot), .vld(vld), .page(page),
    .rbyte(sbyte));

  pgc_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_tmr (
    .clk(clk), .rst(rst), .go(go), .busy(busy), .slot(slot),
    .slot_live(slot_live), .done(done));

  pgc_array #(.DEPTH(PAGES * PAGE_BYTES), .DATA_W(DATA_W), .INIT(INIT)) u_arr (
    .clk(clk), .we(slot_live && vld[slot]), .wa({page, slot}), .wd(sbyte),
    .ra(rd_addr), .rd(rd_data));

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= accept;
  end
  assign byte_ack = ack_q;

  AST_COMMIT_RISE: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !busy && !wp && (|vld)) |=> busy);                   // R4
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> !byte_ack);                                              // R8
  AST_WP_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    wp |=> !byte_ack);                                                // R6
  AST_WP_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (stop_req && wp && !busy) |=> !busy);                             // R6
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !busy && (vld == '0)) |=> !busy);                    // R9
endmodule

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;
  localparam int W = 20;

  typedef struct packed {
    logic        wp;
    logic [4:0]  n;
    logic [7:0]  seed;
    logic [10:0] addr;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 5'd1,  8'h11, 11'h005},
    '{1'b0, 5'd16, 8'h40, 11'h123},
    '{1'b0, 5'd19, 8'h80, 11'h7F0},
    '{1'b1, 5'd4,  8'hC0, 11'h200},
    '{1'b0, 5'd3,  8'h21, 11'h00E},
    '{1'b0, 5'd2,  8'h5A, 11'h7F4}
  };

  logic clk = 0, rst = 1, byte_stb = 0, stop_req = 0, start_seen = 0, wp = 0;
  logic [10:0] byte_addr = '0, rd_addr = '0;
  logic [7:0]  byte_data = '0, rd_data;
  logic        byte_ack, busy;
  logic [7:0]  model [2048];
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  page_commit_ctrl #(.WR_CYCLES(W)) uut (
    .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_addr(byte_addr),
    .byte_data(byte_data), .stop_req(stop_req), .start_seen(start_seen),
    .wp(wp), .rd_addr(rd_addr), .rd_data(rd_data), .byte_ack(byte_ack),
    .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [10:0] a, input logic [7:0] d, output logic ack);
    byte_stb = 1; byte_addr = a; byte_data = d;
    @(negedge clk);
    ack = byte_ack;
    byte_stb = 0;
  endtask

  task automatic pulse_start();
    start_seen = 1; @(negedge clk); start_seen = 0;
  endtask

  // stop pulse; returns number of cycles busy was seen high
  task automatic do_stop(output int len);
    stop_req = 1; @(negedge clk); stop_req = 0;
    len = 0;
    while (busy && len < 10 * W) begin
      len++; @(negedge clk);
    end
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    rd_addr = a; @(negedge clk); d = rd_data;
  endtask

  task automatic check_page(input logic [10:0] a, input string req);
    logic [7:0] d;
    for (int c = 0; c < 16; c++) begin
      rd({a[10:4], 4'(c)}, d);
      chk(d == model[{a[10:4], 4'(c)}], req, d, model[{a[10:4], 4'(c)}]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int len;
    for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(byte_ack == 0, "R1 ack", byte_ack, 0);

    // table-driven page writes
    for (int v = 0; v < 6; v++) begin
      pulse_start();
      wp = VEC[v].wp;
      for (int i = 0; i < int'(VEC[v].n); i++) begin
        send(VEC[v].addr + 11'(i * 5), VEC[v].seed + 8'(i * 7), ack);
        chk(ack == !VEC[v].wp, VEC[v].wp ? "R6 ack" : "R11 ack", ack, !VEC[v].wp);
        if (!VEC[v].wp)
          model[{VEC[v].addr[10:4], 4'(VEC[v].addr[3:0] + 4'(i))}] = VEC[v].seed + 8'(i * 7);
      end
      do_stop(len);
      chk(len == (VEC[v].wp ? 0 : W), VEC[v].wp ? "R6 busy" : "R4 window", len,
          VEC[v].wp ? 0 : W);
      wp = 0;
      check_page(VEC[v].addr, v == 2 ? "R3 wrap" : (v >= 4 ? "R5 keep" : "R2 load"));
    end

    // R8: strobe during busy ignored
    pulse_start();
    send(11'h300, 8'hAA, ack); model[11'h300] = 8'hAA;
    stop_req = 1; @(negedge clk); stop_req = 0;
    chk(busy == 1, "R4 rise", busy, 1);
    send(11'h301, 8'h77, ack);
    chk(ack == 0, "R8 ack", ack, 0);
    while (busy) @(negedge clk);
    do_stop(len);
    chk(len == 0, "R9 empty", len, 0);
    check_page(11'h300, "R8 array");

    // R7: start discards staged bytes
    send(11'h400, 8'h12, ack);
    send(11'h400, 8'h34, ack);
    pulse_start();
    do_stop(len);
    chk(len == 0, "R7 no window", len, 0);
    rd(11'h400, d);
    chk(d == 8'hFF, "R7 array", d, 8'hFF);

    // R6: protection raised after loading
    send(11'h410, 8'h56, ack);
    chk(ack == 1, "R11 ack", ack, 1);
    wp = 1;
    do_stop(len);
    chk(len == 0, "R6 late wp", len, 0);
    wp = 0;
    do_stop(len);
    chk(len == 0, "R6 discarded", len, 0);
    rd(11'h410, d);
    chk(d == 8'hFF, "R6 array", d, 8'hFF);
    rd(11'h005, d);
    chk(d == 8'h11, "R10 read", d, 8'h11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule